// File: doc/BRIEF.md
# Microcode Sequencer with Encoded Next-Address Types

This block is the control half of a microprogrammed processor. A six-bit micro-program counter selects a word in an internal control store. The control store is computed from a function, so it has no separate memory image. Each word holds an 18-bit bundle of datapath control signals and a three-bit next-address type. The sequencer has no full next-address field in each word. It builds the following micro-address from four sources: the current address plus one, a fixed fetch entry, a decoder that maps the macro-opcode to the first step of its routine, or the current address held in place while memory is still busy.

The block drives a single-bus datapath that lies outside it. Each cycle the datapath receives the control word for the current micro-address. The datapath returns a condition flag from its comparator and a busy flag from memory, and the instruction register supplies a five-bit opcode field. The sequencer reads the opcode only on the dispatch step at the end of instruction fetch. It reads the condition only on the two conditional-exit types. It reads busy only on the spin type.

The three-bit type field is encoded as follows: advance=0, spin=1, fetch=2, dispatch=3, exit-on-true=4, exit-on-false=5. Every address with no step defined holds a zero control word and the fetch type.

Top module: `ucode_seq`

## Requirements
- R1: A synchronous reset sets the micro-address to 0, the first fetch step. While reset is held, the control word is 0x00181.
- R2: On an advance step, the next micro-address is the current one plus one. The busy, condition and opcode inputs have no effect on it.
- R3: On a spin step, the micro-address holds its value in every cycle that busy is 1. In the first cycle that busy is 0, it moves to the current address plus one.
- R4: On a fetch-type step, the next micro-address is 0.
- R5: On a dispatch step, the next micro-address comes from the opcode: 0x0C gives 3, 0x04 gives 6, 0x00 gives 9, 0x18 gives 14 and 0x1C gives 21.
- R6: Any other opcode on a dispatch step gives micro-address 20. Address 20 emits control word 0 and returns to 0 on the next cycle.
- R7: On an exit-on-false step, the next micro-address is 0 when the condition is 0, and the current address plus one when it is 1.
- R8: On an exit-on-true step, the next micro-address is 0 when the condition is 1, and the current address plus one when it is 0.
- R9: Instruction fetch takes three steps: address 0 advances with word 0x00181, address 1 spins with word 0x00420, and address 2 dispatches with word 0x04808.
- R10: The routines are laid out as follows.
  - Register ALU: addresses 3 to 5, ending with fetch.
  - Immediate ALU: addresses 6 to 8, ending with fetch.
  - Load: addresses 9 to 13, with a spin at 12 and fetch at 13.
  - Branch: addresses 14 to 19, with exit-on-false at 16 and fetch at 19.
  - Conditional skip: addresses 21 to 23, with exit-on-true at 22 and fetch at 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on the rising edge |
| rst | input | 1 | Synchronous active-high reset to the fetch entry |
| opcode | input | 5 | Opcode field from the instruction register, read on dispatch |
| cond | input | 1 | Condition result from the datapath comparator |
| busy | input | 1 | Memory busy flag, read on spin steps |
| upc | output | 6 | Current micro-program counter |
| ctrl | output | 18 | Control word for the current micro-address |

## Verification
The micro-address is the only state in the block, so a wrong next-address decision shows on `upc` in the cycle right after the step that made it. The control word changes in that same cycle. A wrong decision does not stay hidden. It either leaves the fixed routine layout at once, or it loops back to address 0 too early, and a trace check against the expected step list catches either case. The bench sets busy, condition and opcode to misleading values on the steps that must ignore them. Any wrongly decoded jump type then moves the trace away from the expected list within one cycle.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

   typedef enum logic [2:0] {
      JT_NEXT     = 3'd0,
      JT_SPIN     = 3'd1,
      JT_FETCH    = 3'd2,
      JT_DISPATCH = 3'd3,
      JT_FTRUE    = 3'd4,
      JT_FFALSE   = 3'd5
   } jump_t;

   // bit 17 down to bit 0
   typedef struct packed {
      logic       imm_branch;
      logic [1:0] reg_sel;
      logic [2:0] alu_fn;
      logic       pc_ld;
      logic       ir_ld;
      logic       b_ld;
      logic       a_ld;
      logic       ma_ld;
      logic       mem_we;
      logic       mem_oe;
      logic       imm_oe;
      logic       alu_oe;
      logic       reg_we;
      logic       reg_oe;
      logic       pc_oe;
   } ctrl_t;

   typedef struct packed {
      jump_t jt;
      ctrl_t ctrl;
   } uword_t;

   localparam logic [2:0] AF_NONE = 3'd0;
   localparam logic [2:0] AF_ADD  = 3'd1;
   localparam logic [2:0] AF_INST = 3'd2;
   localparam logic [2:0] AF_CMP  = 3'd3;
   localparam logic [2:0] AF_INC4 = 3'd4;
   localparam logic [2:0] AF_DEC4 = 3'd5;

   localparam logic [1:0] SEL_RS1 = 2'd0;
   localparam logic [1:0] SEL_RS2 = 2'd1;
   localparam logic [1:0] SEL_RD  = 2'd2;

   localparam int ENT_FETCH = 0;
   localparam int ENT_ALU   = 3;
   localparam int ENT_ALUI  = 6;
   localparam int ENT_LOAD  = 9;
   localparam int ENT_BR    = 14;
   localparam int ENT_ILL   = 20;
   localparam int ENT_SKIP  = 21;
   localparam int ENT_LAST  = 23;

   localparam logic [4:0] OPC_LOAD = 5'h00;
   localparam logic [4:0] OPC_ALUI = 5'h04;
   localparam logic [4:0] OPC_ALU  = 5'h0C;
   localparam logic [4:0] OPC_BR   = 5'h18;
   localparam logic [4:0] OPC_SKIP = 5'h1C;

   function automatic uword_t rom_word(input int a);
      uword_t w;
      w    = '0;
      w.jt = JT_FETCH;
      case (a)
         0:  begin w.ctrl.pc_oe = 1'b1; w.ctrl.ma_ld = 1'b1; w.ctrl.a_ld = 1'b1; w.jt = JT_NEXT; end
         1:  begin w.ctrl.mem_oe = 1'b1; w.ctrl.ir_ld = 1'b1; w.jt = JT_SPIN; end
         2:  begin w.ctrl.alu_oe = 1'b1; w.ctrl.pc_ld = 1'b1; w.ctrl.alu_fn = AF_INC4; w.jt = JT_DISPATCH; end
         3, 6, 9, 14, 21:
             begin w.ctrl.reg_oe = 1'b1; w.ctrl.reg_sel = SEL_RS1; w.ctrl.a_ld = 1'b1; w.jt = JT_NEXT; end
         4, 15:
             begin w.ctrl.reg_oe = 1'b1; w.ctrl.reg_sel = SEL_RS2; w.ctrl.b_ld = 1'b1; w.jt = JT_NEXT; end
         7, 10:
             begin w.ctrl.imm_oe = 1'b1; w.ctrl.b_ld = 1'b1; w.jt = JT_NEXT; end
         5, 8, 23:
             begin w.ctrl.alu_oe = 1'b1; w.ctrl.alu_fn = AF_INST; w.ctrl.reg_we = 1'b1;
                   w.ctrl.reg_sel = SEL_RD; w.jt = JT_FETCH; end
         11: begin w.ctrl.alu_oe = 1'b1; w.ctrl.alu_fn = AF_ADD; w.ctrl.ma_ld = 1'b1; w.jt = JT_NEXT; end
         12: w.jt = JT_SPIN;
         13: begin w.ctrl.mem_oe = 1'b1; w.ctrl.reg_we = 1'b1; w.ctrl.reg_sel = SEL_RD; w.jt = JT_FETCH; end
         16: begin w.ctrl.alu_fn = AF_CMP; w.ctrl.pc_oe = 1'b1; w.ctrl.a_ld = 1'b1; w.jt = JT_FFALSE; end
         17: begin w.ctrl.alu_oe = 1'b1; w.ctrl.alu_fn = AF_DEC4; w.ctrl.a_ld = 1'b1; w.jt = JT_NEXT; end
         18: begin w.ctrl.imm_oe = 1'b1; w.ctrl.imm_branch = 1'b1; w.ctrl.b_ld = 1'b1; w.jt = JT_NEXT; end
         19: begin w.ctrl.alu_oe = 1'b1; w.ctrl.alu_fn = AF_ADD; w.ctrl.pc_ld = 1'b1; w.jt = JT_FETCH; end
         22: begin w.ctrl.alu_fn = AF_CMP; w.jt = JT_FTRUE; end
         default: w.jt = JT_FETCH;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/ucseq_store.sv
module ucseq_store
   import ucseq_pkg::*;
#(
   parameter int UPC_W = 6
) (
   input  logic [UPC_W-1:0] addr,
   output uword_t           word
);
   localparam int DEPTH = 1 << UPC_W;

   uword_t table_w [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      assign table_w[g] = rom_word(g);
   end

   assign word = table_w[addr];
endmodule

// File: rtl/ucseq_dispatch.sv
module ucseq_dispatch
   import ucseq_pkg::*;
#(
   parameter int OP_W  = 5,
   parameter int UPC_W = 6
) (
   input  logic [OP_W-1:0]  opcode,
   output logic [UPC_W-1:0] entry
);
   always_comb begin
      if      (opcode == OP_W'(OPC_ALU))  entry = UPC_W'(ENT_ALU);
      else if (opcode == OP_W'(OPC_ALUI)) entry = UPC_W'(ENT_ALUI);
      else if (opcode == OP_W'(OPC_LOAD)) entry = UPC_W'(ENT_LOAD);
      else if (opcode == OP_W'(OPC_BR))   entry = UPC_W'(ENT_BR);
      else if (opcode == OP_W'(OPC_SKIP)) entry = UPC_W'(ENT_SKIP);
      else                                entry = UPC_W'(ENT_ILL);
   end
endmodule

// File: rtl/ucseq_next.sv
module ucseq_next
   import ucseq_pkg::*;
#(
   parameter int UPC_W = 6
) (
   input  logic [UPC_W-1:0] upc,
   input  jump_t            jt,
   input  logic             busy,
   input  logic             cond,
   input  logic [UPC_W-1:0] entry,
   output logic [UPC_W-1:0] nxt
);
   localparam logic [UPC_W-1:0] FETCH0 = UPC_W'(ENT_FETCH);

   logic [UPC_W-1:0] incr;
   assign incr = upc + 1'b1;

   always_comb begin
      case (jt)
         JT_NEXT:     nxt = incr;
         JT_SPIN:     nxt = busy ? upc : incr;
         JT_FETCH:    nxt = FETCH0;
         JT_DISPATCH: nxt = entry;
         JT_FTRUE:    nxt = cond ? FETCH0 : incr;
         JT_FFALSE:   nxt = cond ? incr : FETCH0;
         default:     nxt = FETCH0;
      endcase
   end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
   import ucseq_pkg::*;
#(
   parameter int UPC_W  = 6,
   parameter int OP_W   = 5,
   parameter int CTRL_W = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [OP_W-1:0]   opcode,
   input  logic              cond,
   input  logic              busy,
   output logic [UPC_W-1:0]  upc,
   output logic [CTRL_W-1:0] ctrl
);
   localparam int              ROUTINE_END = ENT_LAST + 1;
   localparam logic [UPC_W-1:0] FETCH0     = UPC_W'(ENT_FETCH);

   if (UPC_W < $clog2(ROUTINE_END)) begin : g_bad_upc
      $error("UPC_W too narrow for the routine layout");
   end
   if (OP_W < 5) begin : g_bad_op
      $error("OP_W must hold the opcode values");
   end
   if (CTRL_W != $bits(ctrl_t)) begin : g_bad_ctrl
      $error("CTRL_W must match the control word");
   end

   logic [UPC_W-1:0] upc_q;
   logic [UPC_W-1:0] upc_d;
   logic [UPC_W-1:0] entry;
   uword_t           word;

   ucseq_store #(.UPC_W(UPC_W)) u_store (
      .addr (upc_q),
      .word (word)
   );

   ucseq_dispatch #(.OP_W(OP_W), .UPC_W(UPC_W)) u_disp (
      .opcode (opcode),
      .entry  (entry)
   );

   ucseq_next #(.UPC_W(UPC_W)) u_next (
      .upc   (upc_q),
      .jt    (word.jt),
      .busy  (busy),
      .cond  (cond),
      .entry (entry),
      .nxt   (upc_d)
   );

   always_ff @(posedge clk) begin
      if (rst) upc_q <= FETCH0;
      else     upc_q <= upc_d;
   end

   assign upc  = upc_q;
   assign ctrl = CTRL_W'(word.ctrl);

   AST_RESET_ENTRY: assert property (@(posedge clk) rst |=> upc == FETCH0); // R1
   AST_NEXT_INC: assert property (@(posedge clk) disable iff (rst)
      word.jt == JT_NEXT |=> upc == $past(upc) + 1'b1); // R2
   AST_SPIN_HOLD: assert property (@(posedge clk) disable iff (rst)
      (word.jt == JT_SPIN && busy) |=> $stable(upc)); // R3
   AST_FETCH_ENTRY: assert property (@(posedge clk) disable iff (rst)
      word.jt == JT_FETCH |=> upc == FETCH0); // R4
   AST_FALSE_EXIT: assert property (@(posedge clk) disable iff (rst)
      (word.jt == JT_FFALSE && !cond) |=> upc == FETCH0); // R7
   AST_TRUE_EXIT: assert property (@(posedge clk) disable iff (rst)
      (word.jt == JT_FTRUE && cond) |=> upc == FETCH0); // R8
   AST_ILLEGAL_EMPTY: assert property (@(posedge clk) disable iff (rst)
      upc == UPC_W'(ENT_ILL) |-> ctrl == '0); // R6
endmodule

// File: tb/sim_ucode_seq.sv
module sim_ucode_seq;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] opcode = 5'h00;
   logic       cond = 1'b0;
   logic       busy = 1'b0;
   logic [5:0] upc;
   logic [17:0] ctrl;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   localparam logic [4:0] OP_LOAD = 5'h00;
   localparam logic [4:0] OP_ALUI = 5'h04;
   localparam logic [4:0] OP_ALU  = 5'h0C;
   localparam logic [4:0] OP_BR   = 5'h18;
   localparam logic [4:0] OP_SKIP = 5'h1C;

   typedef struct {
      logic [5:0] addr;
      string      tag;
   } exp_t;

   exp_t q[$];

   always #5 clk = ~clk;

   ucode_seq u0 (
      .clk    (clk),
      .rst    (rst),
      .opcode (opcode),
      .cond   (cond),
      .busy   (busy),
      .upc    (upc),
      .ctrl   (ctrl)
   );

   // control words that the requirements fix for particular addresses (R9, R6)
   function automatic bit known_ctrl(input logic [5:0] a, output logic [17:0] w);
      case (a)
         6'd0:  begin w = 18'h00181; return 1'b1; end
         6'd1:  begin w = 18'h00420; return 1'b1; end
         6'd2:  begin w = 18'h04808; return 1'b1; end
         6'd20: begin w = 18'h00000; return 1'b1; end
         default: begin w = '0; return 1'b0; end
      endcase
   endfunction

   // monitor
   always @(negedge clk) begin
      if (!rst && q.size() > 0) begin
         exp_t e;
         logic [17:0] w;
         e = q.pop_front();
         checks++;
         if (upc !== e.addr) begin
            errors++;
            $display("FAIL %s: upc=%0d expected %0d", e.tag, upc, e.addr);
         end
         if (known_ctrl(e.addr, w)) begin
            checks++;
            if (ctrl !== w) begin
               errors++;
               $display("FAIL %s (R9/R6 ctrl at %0d): ctrl=%h expected %h", e.tag, e.addr, ctrl, w);
            end
         end
      end
   end

   // driver: push expectation for the current state, drive inputs consumed at next edge
   task automatic step(input logic [5:0] a, input logic [4:0] op, input logic c,
                       input logic b, input string tag);
      exp_t e;
      e.addr = a;
      e.tag  = tag;
      q.push_back(e);
      opcode = op;
      cond   = c;
      busy   = b;
      @(posedge clk);
      #1;
   endtask

   task automatic run_instr(input logic [4:0] op, input int fb, input int mb, input logic c);
      step(6'd0, ~op, ~c, 1'b1, "R2 advance ignores busy");
      for (int i = 0; i < fb; i++) step(6'd1, ~op, ~c, 1'b1, "R3 spin holds");
      step(6'd1, ~op, ~c, 1'b0, "R3 spin release");
      step(6'd2, op, ~c, 1'b1, "R5 dispatch");
      case (op)
         OP_ALU: begin
            step(6'd3, ~op, ~c, 1'b1, "R5 R10 alu");
            step(6'd4, ~op, ~c, 1'b1, "R10 alu");
            step(6'd5, ~op, ~c, 1'b1, "R10 alu");
         end
         OP_ALUI: begin
            step(6'd6, ~op, ~c, 1'b1, "R5 R10 alui");
            step(6'd7, ~op, ~c, 1'b1, "R10 alui");
            step(6'd8, ~op, ~c, 1'b1, "R10 alui");
         end
         OP_LOAD: begin
            step(6'd9,  ~op, ~c, 1'b1, "R5 R10 load");
            step(6'd10, ~op, ~c, 1'b1, "R10 load");
            step(6'd11, ~op, ~c, 1'b1, "R10 load");
            for (int i = 0; i < mb; i++) step(6'd12, ~op, ~c, 1'b1, "R3 load spin");
            step(6'd12, ~op, ~c, 1'b0, "R3 load release");
            step(6'd13, ~op, ~c, 1'b1, "R10 load");
         end
         OP_BR: begin
            step(6'd14, ~op, ~c, 1'b1, "R5 R10 branch");
            step(6'd15, ~op, ~c, 1'b1, "R10 branch");
            step(6'd16, ~op, c, 1'b1, "R7 exit-on-false");
            if (c) begin
               step(6'd17, ~op, ~c, 1'b1, "R7 taken path");
               step(6'd18, ~op, ~c, 1'b1, "R10 branch");
               step(6'd19, ~op, ~c, 1'b1, "R10 branch");
            end
         end
         OP_SKIP: begin
            step(6'd21, ~op, ~c, 1'b1, "R5 R10 skip");
            step(6'd22, ~op, c, 1'b1, "R8 exit-on-true");
            if (!c) step(6'd23, ~op, ~c, 1'b1, "R8 fall through");
         end
         default: step(6'd20, ~op, ~c, 1'b1, "R6 illegal entry");
      endcase
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (upc !== 6'd0 || ctrl !== 18'h00181) begin
         errors++;
         $display("FAIL R1: upc=%0d ctrl=%h expected 0 / 00181", upc, ctrl);
      end
      @(posedge clk);
      #1;
      rst = 1'b0;
   endtask

   initial begin
      @(posedge clk);
      #1;
      do_reset();
      run_instr(OP_ALU,  2, 0, 1'b0);
      run_instr(OP_ALUI, 0, 0, 1'b1);
      run_instr(OP_LOAD, 1, 3, 1'b0);
      run_instr(OP_BR,   0, 0, 1'b0);
      run_instr(OP_BR,   1, 0, 1'b1);
      run_instr(OP_SKIP, 0, 0, 1'b1);
      run_instr(OP_SKIP, 0, 0, 1'b0);
      run_instr(5'h1F,   0, 0, 1'b0);
      run_instr(5'h08,   1, 0, 1'b1);
      // reset in the middle of a branch routine (R1)
      step(6'd0, 5'h00, 1'b0, 1'b0, "R2");
      step(6'd1, 5'h00, 1'b0, 1'b0, "R3");
      step(6'd2, OP_BR, 1'b0, 1'b0, "R5");
      step(6'd14, 5'h00, 1'b0, 1'b0, "R10");
      do_reset();
      run_instr(OP_ALU, 0, 0, 1'b1);
      step(6'd0, 5'h00, 1'b1, 1'b1, "R4 return to fetch");
      @(negedge clk);
      @(negedge clk);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R2: %0d expectations left, expected 0", q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule